// File: doc/BRIEF.md
# Sector protection command decoder

This block sits on the write/read strobe side of a flash-style memory port and decodes the protection command language. A three-cycle unlock prefix selects one of five protection command sets: the lock register, the password, the persistent per-sector bits, the persistent lock bit and the dynamic per-sector bits. Inside a set, the block accepts program, erase, set, clear and status-read commands. A two-cycle exit takes it back to array read mode. The protection state lives in flip-flops: a 3-bit one-time-programmable lock register, four 16-bit password words, one persistent bit and one dynamic bit for each sector, and the persistent lock bit.

The write cycle is sampled on the rising clock edge while `wr_en` is high. A read cycle (`rd_en`) returns the registered result one edge later. In read mode that result is the placeholder `array_data`. Inside a set it is that set's status or register value. Command matching looks only at address bits 11:0 and data bits 7:0. The sector number comes from the address bits above bit 11.

States: `ST_READ` (array read), `ST_UNL1` (first unlock seen), `ST_UNL2` (second unlock seen), `ST_CMD` (inside a set, waiting for a command), `ST_PROG` (program prefix seen), `ST_ERA1` (erase prefix seen), `ST_ERA_PRG` (erase step that sets all bits), `ST_ERA_CLR` (erase step that clears all bits) and `ST_EXIT1` (exit prefix seen).

Transitions:
- `ST_READ` goes to `ST_UNL1` on `AA`@`AAA`. `ST_UNL1` goes to `ST_UNL2` on `55`@`555`. `ST_UNL2` goes to `ST_CMD` on a valid set code @`AAA`. Any other write in these three states goes to `ST_READ`.
- `ST_CMD` goes to `ST_PROG` on `A0`, to `ST_EXIT1` on `90`, and to `ST_ERA1` on `80` in the persistent set.
- `ST_PROG` goes to `ST_CMD` on any write, or to `ST_READ` on a lock register abort.
- `ST_ERA1` goes to `ST_ERA_PRG` on `30`@`000`, otherwise to `ST_CMD`.
- `ST_ERA_PRG` goes to `ST_ERA_CLR`, and `ST_ERA_CLR` goes to `ST_CMD`.
- `ST_EXIT1` goes to `ST_READ` on `00`, otherwise to `ST_CMD`.

Top module: `prot_cmd_top`

## Requirements
- R1: After reset `active_set` is 0 (read mode), `pers_prot`, `dyn_prot` and `pers_lock` are all 0, `lock_bits` is 3'b111 and every password word is FFFFh.
- R2: Three writes select a set: `AA`@`AAA`, then `55`@`555`, then a code @`AAA`. Each code shows on `active_set` right after the third write: 40h gives 1 (lock register), 60h gives 2 (password), C0h gives 3 (persistent bits), 50h gives 4 (persistent lock), E0h gives 5 (dynamic bits).
- R3: A write that breaks the unlock prefix, or an unknown set code, leaves `active_set` at 0.
- R4: Writing 90h and then 00h inside a set returns `active_set` to 0. Any other command write inside a set keeps the set active.
- R5: A read in read mode returns `array_data` on `rdata` one edge after the read strobe.
- R6: In the dynamic set, `A0` followed by 00h at a sector sets that sector's `dyn_prot` bit, and `A0` followed by 01h clears it. A read at a sector returns 0000h when its bit is set and 0001h when it is clear.
- R7: In the persistent set, `A0` followed by 00h at a sector sets that sector's `pers_prot` bit. The status read uses the same 0000h/0001h encoding as R6.
- R8: In the persistent set, 80h followed by 30h at address 000h makes every `pers_prot` bit 1 one edge later, and every bit 0 the edge after that.
- R9: In the persistent lock set, `A0` followed by 00h sets `pers_lock`, whose status read is 0000h when set and 0001h when clear. While it is set, persistent program and erase change no `pers_prot` bit. Only reset clears it.
- R10: A lock register program ANDs data bits 2:0 into `lock_bits`, so a 0 bit can never return to 1. A read in the lock set returns {13 ones, `lock_bits`}.
- R11: A lock register program whose data has bits 1 and 2 both 0 changes nothing and returns `active_set` to 0.
- R12: In the password set, `A0` followed by a write at word index addr[1:0] ANDs the data into that word. `pwd_flat` carries word w in bits 16w+15:16w, and a read returns the word that addr[1:0] selects.
- R13: Data bits 15:8 and the sector address bits are ignored in unlock and command cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write cycle strobe |
| rd_en | input | 1 | Read cycle strobe |
| addr | input | ADDR_W (15) | Bits 14:12 give the sector, bits 11:0 give the command address |
| wdata | input | 16 | Write data |
| array_data | input | 16 | Placeholder array word returned in read mode |
| rdata | output | 16 | Registered read result |
| active_set | output | 3 | Selected command set: 0 none, 1 to 5 as in R2 |
| pers_prot | output | NSEC (8) | Persistent protection bit for each sector, 1 = protected |
| dyn_prot | output | NSEC (8) | Dynamic protection bit for each sector, 1 = protected |
| pers_lock | output | 1 | Persistent lock bit |
| lock_bits | output | 3 | Lock register bits 2:0 |
| pwd_flat | output | 64 | Four password words |

## Verification
Protection bits, `active_set`, `pers_lock`, `lock_bits` and `pwd_flat` change on the same edge that samples the last write of a command. The bench drives every cycle on a falling edge and checks at the next falling edge, which falls just after that write's edge. `rdata` also becomes valid on the edge that samples the read strobe, so it is checked at the falling edge that ends the read. The erase command is the only case with a delay. Its all-ones step is checked one full cycle after the 30h write, and its all-zeros step one cycle after that.

// File: rtl/prot_pkg.sv
package prot_pkg;
    localparam int CMD_AW = 12;
    localparam int DATA_W = 16;
    localparam int PWD_WORDS = 4;

    localparam logic [CMD_AW-1:0] ADR_HI = 12'hAAA;
    localparam logic [CMD_AW-1:0] ADR_LO = 12'h555;
    localparam logic [CMD_AW-1:0] ADR_ZERO = 12'h000;

    localparam logic [7:0] CD_UNL1 = 8'hAA;
    localparam logic [7:0] CD_UNL2 = 8'h55;
    localparam logic [7:0] CD_PROG = 8'hA0;
    localparam logic [7:0] CD_ERA1 = 8'h80;
    localparam logic [7:0] CD_ERA2 = 8'h30;
    localparam logic [7:0] CD_EXIT1 = 8'h90;
    localparam logic [7:0] CD_EXIT2 = 8'h00;
    localparam logic [7:0] CD_SET0 = 8'h00;
    localparam logic [7:0] CD_CLR1 = 8'h01;

    typedef enum logic [2:0] {
        SET_NONE  = 3'd0,
        SET_LOCK  = 3'd1,
        SET_PWD   = 3'd2,
        SET_PPB   = 3'd3,
        SET_PLOCK = 3'd4,
        SET_DYB   = 3'd5
    } set_e;

    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_CMD, ST_PROG,
        ST_ERA1, ST_ERA_PRG, ST_ERA_CLR, ST_EXIT1
    } st_e;

    typedef struct packed {
        logic lock_prog;
        logic pwd_prog;
        logic ppb_prog;
        logic ppb_all_set;
        logic ppb_all_clr;
        logic plock_set;
        logic dyb_set;
        logic dyb_clr;
    } act_t;
endpackage

// File: rtl/prot_cmd_fsm.sv
module prot_cmd_fsm
    import prot_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CMD_AW-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              pers_lock,
    output st_e               state_q,
    output set_e              set_q,
    output act_t              act
);
    st_e  state_n;
    set_e set_n;
    set_e code_set;
    logic code_ok;
    logic lock_abort;

    always_comb begin
        code_ok  = 1'b1;
        code_set = SET_NONE;
        unique case (cmd_data)
            8'h40:   code_set = SET_LOCK;
            8'h60:   code_set = SET_PWD;
            8'hC0:   code_set = SET_PPB;
            8'h50:   code_set = SET_PLOCK;
            8'hE0:   code_set = SET_DYB;
            default: code_ok = 1'b0;
        endcase
    end

    assign lock_abort = !cmd_data[1] && !cmd_data[2];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READ;
            set_q   <= SET_NONE;
        end else begin
            state_q <= state_n;
            set_q   <= set_n;
        end
    end

    always_comb begin
        state_n = state_q;
        set_n   = set_q;
        unique case (state_q)
            ST_READ: begin
                if (wr_en && cmd_addr == ADR_HI && cmd_data == CD_UNL1)
                    state_n = ST_UNL1;
            end
            ST_UNL1: begin
                if (wr_en)
                    state_n = (cmd_addr == ADR_LO && cmd_data == CD_UNL2) ? ST_UNL2 : ST_READ;
            end
            ST_UNL2: begin
                if (wr_en) begin
                    if (cmd_addr == ADR_HI && code_ok) begin
                        state_n = ST_CMD;
                        set_n   = code_set;
                    end else begin
                        state_n = ST_READ;
                    end
                end
            end
            ST_CMD: begin
                if (wr_en) begin
                    if (cmd_data == CD_PROG)
                        state_n = ST_PROG;
                    else if (cmd_data == CD_EXIT1)
                        state_n = ST_EXIT1;
                    else if (cmd_data == CD_ERA1 && set_q == SET_PPB)
                        state_n = ST_ERA1;
                end
            end
            ST_PROG: begin
                if (wr_en) begin
                    if (set_q == SET_LOCK && lock_abort) begin
                        state_n = ST_READ;
                        set_n   = SET_NONE;
                    end else begin
                        state_n = ST_CMD;
                    end
                end
            end
            ST_ERA1: begin
                if (wr_en)
                    state_n = (cmd_addr == ADR_ZERO && cmd_data == CD_ERA2 && !pers_lock)
                              ? ST_ERA_PRG : ST_CMD;
            end
            ST_ERA_PRG: state_n = ST_ERA_CLR;
            ST_ERA_CLR: state_n = ST_CMD;
            ST_EXIT1: begin
                if (wr_en) begin
                    if (cmd_data == CD_EXIT2) begin
                        state_n = ST_READ;
                        set_n   = SET_NONE;
                    end else begin
                        state_n = ST_CMD;
                    end
                end
            end
            default: begin
                state_n = ST_READ;
                set_n   = SET_NONE;
            end
        endcase
    end

    always_comb begin
        act = '0;
        unique case (state_q)
            ST_PROG: begin
                if (wr_en) begin
                    unique case (set_q)
                        SET_LOCK:  act.lock_prog = !lock_abort;
                        SET_PWD:   act.pwd_prog  = 1'b1;
                        SET_PPB:   act.ppb_prog  = (cmd_data == CD_SET0) && !pers_lock;
                        SET_PLOCK: act.plock_set = (cmd_data == CD_SET0);
                        SET_DYB: begin
                            act.dyb_set = (cmd_data == CD_SET0);
                            act.dyb_clr = (cmd_data == CD_CLR1);
                        end
                        default: act = '0;
                    endcase
                end
            end
            ST_ERA_PRG: act.ppb_all_set = 1'b1;
            ST_ERA_CLR: act.ppb_all_clr = 1'b1;
            default:    act = '0;
        endcase
    end

    // R3: no command set is held while the unlock prefix is in progress
    assert_prefix_none_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ || state_q == ST_UNL1 || state_q == ST_UNL2) |-> set_q == SET_NONE);

    // R2: the lock register code completes entry
    assert_entry_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UNL2 && wr_en && cmd_addr == ADR_HI && cmd_data == 8'h40)
        |=> (set_q == SET_LOCK && state_q == ST_CMD));

    // R4: the second exit cycle returns to read mode
    assert_exit_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXIT1 && wr_en && cmd_data == CD_EXIT2)
        |=> (set_q == SET_NONE && state_q == ST_READ));

    // R8: the set-all step is always followed by the clear-all step
    assert_erase_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_ERA_PRG |=> state_q == ST_ERA_CLR);
endmodule

// File: rtl/prot_bit_store.sv
module prot_bit_store
    import prot_pkg::*;
#(
    parameter int SEC_W = 3,
    localparam int NSEC = 1 << SEC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  act_t               act,
    input  logic [SEC_W-1:0]   sector,
    input  logic [1:0]         word_sel,
    input  logic [DATA_W-1:0]  wdata,
    output logic [NSEC-1:0]    pers_q,
    output logic [NSEC-1:0]    dyn_q,
    output logic               plock_q,
    output logic [2:0]         lock_q,
    output logic [PWD_WORDS*DATA_W-1:0] pwd_flat
);
    logic [PWD_WORDS-1:0][DATA_W-1:0] pwd_q;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        logic hit;
        assign hit = (sector == SEC_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pers_q[s] <= 1'b0;
                dyn_q[s]  <= 1'b0;
            end else begin
                if (act.ppb_all_set)
                    pers_q[s] <= 1'b1;
                else if (act.ppb_all_clr)
                    pers_q[s] <= 1'b0;
                else if (act.ppb_prog && hit)
                    pers_q[s] <= 1'b1;

                if (act.dyb_set && hit)
                    dyn_q[s] <= 1'b1;
                else if (act.dyb_clr && hit)
                    dyn_q[s] <= 1'b0;
            end
        end
    end

    for (genvar w = 0; w < PWD_WORDS; w++) begin : g_pwd
        always_ff @(posedge clk) begin
            if (!rst_n)
                pwd_q[w] <= '1;
            else if (act.pwd_prog && word_sel == 2'(w))
                pwd_q[w] <= pwd_q[w] & wdata;
        end
    end

    assign pwd_flat = pwd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plock_q <= 1'b0;
            lock_q  <= 3'b111;
        end else begin
            if (act.plock_set)
                plock_q <= 1'b1;
            if (act.lock_prog)
                lock_q <= lock_q & wdata[2:0];
        end
    end

    // R9: persistent bits frozen while the persistent lock stays set
    assert_plock_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (plock_q && $past(plock_q)) |-> $stable(pers_q));

    // R10: a programmed lock register bit never returns to one
    assert_lock_otp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q & ~$past(lock_q)) == 3'b000);

    // R8: the set-all step leaves every persistent bit protected
    assert_erase_fill_R8: assert property (@(posedge clk) disable iff (!rst_n)
        act.ppb_all_set |=> pers_q == '1);

    // R6: set and clear are never requested together
    assert_dyb_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(act.dyb_set && act.dyb_clr));
endmodule

// File: rtl/prot_read_mux.sv
module prot_read_mux
    import prot_pkg::*;
#(
    parameter int SEC_W = 3,
    localparam int NSEC = 1 << SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  set_e              set_q,
    input  logic [SEC_W-1:0]  sector,
    input  logic [1:0]        word_sel,
    input  logic [DATA_W-1:0] array_data,
    input  logic [NSEC-1:0]   pers_q,
    input  logic [NSEC-1:0]   dyn_q,
    input  logic              plock_q,
    input  logic [2:0]        lock_q,
    input  logic [PWD_WORDS*DATA_W-1:0] pwd_flat,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [DATA_W-1:0] STAT_PROT  = 16'h0000;
    localparam logic [DATA_W-1:0] STAT_OPEN  = 16'h0001;

    logic [DATA_W-1:0] rd_val;

    always_comb begin
        unique case (set_q)
            SET_LOCK:  rd_val = {{(DATA_W-3){1'b1}}, lock_q};
            SET_PWD:   rd_val = pwd_flat[word_sel*DATA_W +: DATA_W];
            SET_PPB:   rd_val = pers_q[sector] ? STAT_PROT : STAT_OPEN;
            SET_PLOCK: rd_val = plock_q ? STAT_PROT : STAT_OPEN;
            SET_DYB:   rd_val = dyn_q[sector] ? STAT_PROT : STAT_OPEN;
            default:   rd_val = array_data;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_val;
    end

    // R5: read mode passes the array word through
    assert_array_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && set_q == SET_NONE) |=> rdata == $past(array_data));
endmodule

// File: rtl/prot_cmd_top.sv
module prot_cmd_top
    import prot_pkg::*;
#(
    parameter int SEC_W = 3,
    localparam int NSEC = 1 << SEC_W,
    localparam int ADDR_W = CMD_AW + SEC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    input  logic [15:0]       array_data,
    output logic [15:0]       rdata,
    output logic [2:0]        active_set,
    output logic [NSEC-1:0]   pers_prot,
    output logic [NSEC-1:0]   dyn_prot,
    output logic              pers_lock,
    output logic [2:0]        lock_bits,
    output logic [63:0]       pwd_flat
);
    st_e  state_q;
    set_e set_q;
    act_t act;
    logic [SEC_W-1:0] sector;

    assign sector     = addr[ADDR_W-1 -: SEC_W];
    assign active_set = set_q;

    prot_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .cmd_addr (addr[CMD_AW-1:0]),
        .cmd_data (wdata[7:0]),
        .pers_lock(pers_lock),
        .state_q  (state_q),
        .set_q    (set_q),
        .act      (act)
    );

    prot_bit_store #(.SEC_W(SEC_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .act     (act),
        .sector  (sector),
        .word_sel(addr[1:0]),
        .wdata   (wdata),
        .pers_q  (pers_prot),
        .dyn_q   (dyn_prot),
        .plock_q (pers_lock),
        .lock_q  (lock_bits),
        .pwd_flat(pwd_flat)
    );

    prot_read_mux #(.SEC_W(SEC_W)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_en     (rd_en),
        .set_q     (set_q),
        .sector    (sector),
        .word_sel  (addr[1:0]),
        .array_data(array_data),
        .pers_q    (pers_prot),
        .dyn_q     (dyn_prot),
        .plock_q   (pers_lock),
        .lock_q    (lock_bits),
        .pwd_flat  (pwd_flat),
        .rdata     (rdata)
    );

    // R1: read mode while reset is held
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (active_set == 3'd0 && pers_prot == '0 && dyn_prot == '0));
endmodule

// File: tb/tb_prot_cmd_top.sv
module tb_prot_cmd_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [14:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] array_data = 16'hBEEF;
    logic [15:0] rdata;
    logic [2:0]  active_set;
    logic [7:0]  pers_prot;
    logic [7:0]  dyn_prot;
    logic        pers_lock;
    logic [2:0]  lock_bits;
    logic [63:0] pwd_flat;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] rv;

    always #2.5 clk = ~clk;

    prot_cmd_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .array_data(array_data), .rdata(rdata),
        .active_set(active_set), .pers_prot(pers_prot), .dyn_prot(dyn_prot),
        .pers_lock(pers_lock), .lock_bits(lock_bits), .pwd_flat(pwd_flat)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [14:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [14:0] a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic enter(input logic [7:0] code);
        wr(15'h0AAA, 16'h00AA);
        wr(15'h0555, 16'h0055);
        wr(15'h0AAA, {8'h00, code});
    endtask

    task automatic leave();
        wr(15'h0000, 16'h0090);
        wr(15'h0000, 16'h0000);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 set", active_set, 0);
        chk("R1 pers", pers_prot, 0);
        chk("R1 dyn", dyn_prot, 0);
        chk("R1 plock", pers_lock, 0);
        chk("R1 lock", lock_bits, 3'b111);
        chk("R1 pwd", pwd_flat, 64'hFFFF_FFFF_FFFF_FFFF);
        rd(15'h0123, rv);
        chk("R5 array read", rv, 16'hBEEF);
    endtask

    task automatic t_entry_exit();
        enter(8'h40); chk("R2 lock code", active_set, 1);
        rd(15'h0000, rv); chk("R10 reserved ones", rv, 16'hFFFF);
        wr(15'h0000, 16'h00F0); chk("R4 stray cmd stays", active_set, 1);
        leave(); chk("R4 exit", active_set, 0);
        enter(8'h60); chk("R2 pwd code", active_set, 2); leave();
        enter(8'hC0); chk("R2 ppb code", active_set, 3); leave();
        enter(8'h50); chk("R2 plock code", active_set, 4); leave();
        enter(8'hE0); chk("R2 dyb code", active_set, 5);
        wr(15'h0000, 16'h0090); wr(15'h0000, 16'h0011);
        chk("R4 bad second exit", active_set, 5);
        leave(); chk("R4 exit dyb", active_set, 0);
    endtask

    task automatic t_prefix_bad();
        wr(15'h0AAA, 16'h00AA); wr(15'h0555, 16'h0056); wr(15'h0AAA, 16'h0040);
        chk("R3 bad unlock", active_set, 0);
        enter(8'h77); chk("R3 bad code", active_set, 0);
        array_data = 16'h1357;
        rd(15'h0040, rv); chk("R5 array after bad", rv, 16'h1357);
    endtask

    task automatic t_upper_ignored();
        wr(15'h7AAA, 16'h12AA); wr(15'h3555, 16'hFF55); wr(15'h5AAA, 16'h55E0);
        chk("R13 upper bits ignored", active_set, 5);
        wr(15'h6000, 16'hAB90); wr(15'h1000, 16'hCD00);
        chk("R13 exit upper ignored", active_set, 0);
    endtask

    task automatic t_dyb();
        enter(8'hE0);
        wr(15'h0000, 16'h00A0); wr(15'h5000, 16'h0000);
        chk("R6 dyb set", dyn_prot, 8'h20);
        rd(15'h5000, rv); chk("R6 status prot", rv, 16'h0000);
        rd(15'h2000, rv); chk("R6 status open", rv, 16'h0001);
        wr(15'h0000, 16'h00A0); wr(15'h5000, 16'h0001);
        chk("R6 dyb clear", dyn_prot, 8'h00);
        rd(15'h5000, rv); chk("R6 status after clear", rv, 16'h0001);
        leave();
    endtask

    task automatic t_ppb();
        enter(8'hC0);
        wr(15'h0000, 16'h00A0); wr(15'h3000, 16'h0000);
        chk("R7 ppb prog", pers_prot, 8'h08);
        rd(15'h3000, rv); chk("R7 status prot", rv, 16'h0000);
        rd(15'h2000, rv); chk("R7 status open", rv, 16'h0001);
        wr(15'h0000, 16'h0080); wr(15'h0000, 16'h0030);
        @(negedge clk); chk("R8 all programmed", pers_prot, 8'hFF);
        @(negedge clk); chk("R8 all erased", pers_prot, 8'h00);
        rd(15'h3000, rv); chk("R8 status after erase", rv, 16'h0001);
        leave();
    endtask

    task automatic t_lockreg();
        enter(8'h40);
        wr(15'h0000, 16'h00A0); wr(15'h0000, 16'hFFFE);
        chk("R10 prog bit0", lock_bits, 3'b110);
        rd(15'h0000, rv); chk("R10 read", rv, 16'hFFFE);
        wr(15'h0000, 16'h00A0); wr(15'h0000, 16'hFFFF);
        chk("R10 otp hold", lock_bits, 3'b110);
        wr(15'h0000, 16'h00A0); wr(15'h0000, 16'hFFF9);
        chk("R11 abort unchanged", lock_bits, 3'b110);
        chk("R11 abort to read", active_set, 0);
        enter(8'h40);
        wr(15'h0000, 16'h00A0); wr(15'h0000, 16'hFFFD);
        chk("R10 prog bit1", lock_bits, 3'b100);
        leave();
    endtask

    task automatic t_pwd();
        enter(8'h60);
        wr(15'h0000, 16'h00A0); wr(15'h0002, 16'h1234);
        chk("R12 word2", pwd_flat, 64'hFFFF_1234_FFFF_FFFF);
        rd(15'h0002, rv); chk("R12 read word2", rv, 16'h1234);
        rd(15'h0000, rv); chk("R12 read word0", rv, 16'hFFFF);
        wr(15'h0000, 16'h00A0); wr(15'h0002, 16'hFF00);
        chk("R12 and", pwd_flat, 64'hFFFF_1200_FFFF_FFFF);
        leave();
    endtask

    task automatic t_plock();
        enter(8'hC0);
        wr(15'h0000, 16'h00A0); wr(15'h1000, 16'h0000);
        chk("R7 ppb sec1", pers_prot, 8'h02);
        leave();
        enter(8'h50);
        rd(15'h0000, rv); chk("R9 status clear", rv, 16'h0001);
        wr(15'h0000, 16'h00A0); wr(15'h0000, 16'h0000);
        chk("R9 plock set", pers_lock, 1);
        rd(15'h0000, rv); chk("R9 status set", rv, 16'h0000);
        leave();
        enter(8'hC0);
        wr(15'h0000, 16'h00A0); wr(15'h7000, 16'h0000);
        chk("R9 prog blocked", pers_prot, 8'h02);
        wr(15'h0000, 16'h0080); wr(15'h0000, 16'h0030);
        @(negedge clk); chk("R9 erase blocked a", pers_prot, 8'h02);
        @(negedge clk); chk("R9 erase blocked b", pers_prot, 8'h02);
        leave();
        do_reset();
        chk("R9 cleared by reset", pers_lock, 0);
    endtask

    initial begin
        t_reset();
        t_entry_exit();
        t_prefix_bad();
        t_upper_ignored();
        t_dyb();
        t_ppb();
        t_lockreg();
        t_pwd();
        t_plock();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule